// File: doc/BRIEF.md
# Keyed Reset Control Register

This block holds two software-visible registers on a plain 32-bit register bus: a lock word and a reset-control word. The reset-control word is guarded. It accepts a write only while the lock word holds a 16-bit unlock key, and software sets that key by writing it to the lock register. A write to the lock register with any other value stores that value with bit 15 cleared, and the register stays locked.

An accepted write to the reset-control register stores the full data word as the reset level. If a board-specific trigger bit is set in that data, the block also raises a one-cycle reset request. A board-variant parameter picks the trigger bit. On some variants the reset-control register is reserved: it reads as zero and takes no writes.

The bus has an address, a write strobe and write data. Reads are combinational from the address, so a read needs no strobe.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: A lock-register write whose full 32-bit data equals 0x0000A05F stores 0xA05F. That value unlocks the reset-control register.
- R2: A lock-register write of any other data stores the low 16 bits ANDed with 0x7FFF. A read of the lock register returns the stored 16 bits, zero-extended to 32 bits.
- R3: While the stored lock value differs from 0xA05F, a write to reset control leaves the reset level unchanged and raises no reset request.
- R4: On variant 0, an accepted reset-control write stores all 32 data bits. It requests a reset exactly when data bit 8 is 1.
- R5: On variants 1 and 2, an accepted reset-control write stores all 32 data bits. It requests a reset exactly when data bit 2 is 1.
- R6: On any other variant, the reset-control register reads as zero, and writes to it neither change state nor request a reset.
- R7: After reset, the lock value and the reset level are both zero, so the block starts locked, and the reset request is low.
- R8: The reset request is high for exactly the one cycle after the clock edge that accepts a triggering write.
- R9: The lock register sits at byte offset 0x20 and reset control at 0x40. Every other offset reads as zero, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 12 | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe; a write takes effect at the rising edge where it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the address, the strobe and the data are known and steady across each rising edge. They also assume that a strobe held high for one cycle counts as exactly one write. The bench changes every input on the falling edge only, and each write holds the strobe for a single cycle. The bench reads results on the falling edge, when the combinational read path has settled. Three instances share one bus, so a single write sequence exercises variant 0, variant 1 and a reserved variant side by side.

// File: rtl/rstkey_pkg.sv
package rstkey_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [15:0] STORE_MASK = 16'h7FFF;

  // variants 0..2 implement reset control, all others leave it reserved
  function automatic bit variant_reserved(input int v);
    return !(v == 0 || v == 1 || v == 2);
  endfunction

  function automatic int variant_trig_bit(input int v);
    return (v == 0) ? 8 : 2;
  endfunction
endpackage

// File: rtl/rstkey_lock.sv
module rstkey_lock #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [15:0]       lock_o,
  output logic              unlocked_o
);
  import rstkey_pkg::*;

  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(UNLOCK_KEY);

  logic [15:0] lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else if (wr_i) begin
      if (wdata_i == KEY_WORD) lock_q <= UNLOCK_KEY;
      else                     lock_q <= wdata_i[15:0] & STORE_MASK;
    end
  end

  assign lock_o     = lock_q;
  assign unlocked_o = (lock_q == UNLOCK_KEY);
endmodule

// File: rtl/rstkey_level.sv
module rstkey_level #(
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              unlocked_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] level_o,
  output logic              req_o
);
  import rstkey_pkg::*;

  localparam bit RESERVED = variant_reserved(VARIANT);
  localparam int TRIG     = variant_trig_bit(VARIANT);

  generate
    if (RESERVED) begin : g_reserved
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, wr_i, unlocked_i, wdata_i};
      assign level_o = '0;
      assign req_o   = 1'b0;
    end else begin : g_active
      logic [DATA_W-1:0] level_q;
      logic              req_q;
      logic              accept;

      assign accept = wr_i && unlocked_i;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          level_q <= '0;
          req_q   <= 1'b0;
        end else begin
          req_q <= accept && wdata_i[TRIG];
          if (accept) level_q <= wdata_i;
        end
      end

      assign level_o = level_q;
      assign req_o   = req_q;
    end
  endgenerate
endmodule

// File: rtl/rstkey_rdmux.sv
module rstkey_rdmux #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       lock_i,
  input  logic [DATA_W-1:0] level_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == LOCK_ADDR)      rdata_o = DATA_W'(lock_i);
    else if (addr_i == CTRL_ADDR) rdata_o = level_i;
  end
endmodule

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(32'h40);

  logic [15:0]       lock_q;
  logic              unlocked;
  logic [DATA_W-1:0] level_q;
  logic              wr_lock;
  logic              wr_ctrl;

  assign wr_lock = wr_en_i && (addr_i == LOCK_ADDR);
  assign wr_ctrl = wr_en_i && (addr_i == CTRL_ADDR);

  rstkey_lock #(.DATA_W(DATA_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_lock),
    .wdata_i    (wdata_i),
    .lock_o     (lock_q),
    .unlocked_o (unlocked)
  );

  rstkey_level #(.DATA_W(DATA_W), .VARIANT(VARIANT)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_ctrl),
    .unlocked_i (unlocked),
    .wdata_i    (wdata_i),
    .level_o    (level_q),
    .req_o      (rst_req_o)
  );

  rstkey_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOCK_ADDR(LOCK_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_rdmux (
    .addr_i  (addr_i),
    .lock_i  (lock_q),
    .level_i (level_q),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/keyed_reset_ctrl_chk.sv
module keyed_reset_ctrl_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int VARIANT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rst_req_o,
  input logic [15:0]       lock_q,
  input logic [DATA_W-1:0] level_q
);
  import rstkey_pkg::*;

  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(32'h40);
  localparam logic [DATA_W-1:0] KEY_WORD  = DATA_W'(UNLOCK_KEY);
  localparam int TRIG = variant_trig_bit(VARIANT);

  assert_key_unlocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == LOCK_ADDR && wdata_i == KEY_WORD) |=> (lock_q == UNLOCK_KEY));

  assert_nonkey_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == LOCK_ADDR && wdata_i != KEY_WORD)
      |=> (lock_q == ($past(wdata_i[15:0]) & STORE_MASK)));

  assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == CTRL_ADDR && lock_q != UNLOCK_KEY)
      |=> ($stable(level_q) && !rst_req_o));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(wr_en_i && addr_i == CTRL_ADDR && lock_q == UNLOCK_KEY && wdata_i[TRIG]));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i != LOCK_ADDR && addr_i != CTRL_ADDR) |-> (rdata_o == '0));

  generate
    if (variant_reserved(VARIANT)) begin : g_rsv
      assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == CTRL_ADDR) |-> (rdata_o == '0 && !rst_req_o));
    end
  endgenerate
endmodule

bind keyed_reset_ctrl keyed_reset_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VARIANT(VARIANT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rst_req_o (rst_req_o),
  .lock_q    (lock_q),
  .level_q   (level_q)
);

// File: tb/keyed_reset_ctrl_bench.sv
module keyed_reset_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_v0, rd_v1, rd_v3;
  logic        req_v0, req_v1, req_v3;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  keyed_reset_ctrl #(.VARIANT(0)) u_keyed_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rd_v0), .rst_req_o(req_v0));
  keyed_reset_ctrl #(.VARIANT(1)) u_keyed_reset_ctrl_v1 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rd_v1), .rst_req_o(req_v1));
  keyed_reset_ctrl #(.VARIANT(3)) u_keyed_reset_ctrl_v3 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rd_v3), .rst_req_o(req_v3));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write strobe held for one cycle; returns at the falling edge after the accepting edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_addr(input logic [11:0] a);
    addr = a;
    #1;
  endtask

  task automatic t_reset();
    set_addr(12'h020);
    check("R7 lock after reset", rd_v0, 32'h0);
    set_addr(12'h040);
    check("R7 level after reset", rd_v0, 32'h0);
    check("R7 no request after reset", {29'b0, req_v0, req_v1, req_v3}, 32'h0);
  endtask

  task automatic t_lock_mask();
    bus_write(12'h020, 32'h0000_FFFF);
    set_addr(12'h020);
    check("R2 bit15 cleared", rd_v0, 32'h0000_7FFF);
    bus_write(12'h020, 32'h0001_A05F);
    set_addr(12'h020);
    check("R2 key in low half only", rd_v0, 32'h0000_205F);
  endtask

  task automatic t_locked_ignore();
    bus_write(12'h040, 32'h0000_0104);
    check("R3 no request while locked", {30'b0, req_v0, req_v1}, 32'h0);
    set_addr(12'h040);
    check("R3 level kept while locked", rd_v0, 32'h0);
  endtask

  task automatic t_unlock_fire();
    bus_write(12'h020, 32'h0000_A05F);
    set_addr(12'h020);
    check("R1 key stored", rd_v0, 32'h0000_A05F);
    bus_write(12'h040, 32'h0000_0104);
    check("R8 v0 request pulse", {31'b0, req_v0}, 32'h1);
    check("R5 v1 request pulse", {31'b0, req_v1}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {30'b0, req_v0, req_v1}, 32'h0);
    set_addr(12'h040);
    check("R4 v0 level stored", rd_v0, 32'h0000_0104);
    check("R5 v1 level stored", rd_v1, 32'h0000_0104);
  endtask

  task automatic t_variant_bits();
    bus_write(12'h040, 32'h8000_0100);
    check("R4 bit8 fires v0", {31'b0, req_v0}, 32'h1);
    check("R5 bit8 quiet v1", {31'b0, req_v1}, 32'h0);
    bus_write(12'h040, 32'h0000_0004);
    check("R4 bit2 quiet v0", {31'b0, req_v0}, 32'h1 ^ 32'h1);
    check("R5 bit2 fires v1", {31'b0, req_v1}, 32'h1);
    bus_write(12'h040, 32'h0000_0008);
    check("R4 no trigger bit", {30'b0, req_v0, req_v1}, 32'h0);
    set_addr(12'h040);
    check("R4 level updated", rd_v0, 32'h0000_0008);
  endtask

  task automatic t_reserved();
    set_addr(12'h040);
    check("R6 reserved reads zero", rd_v3, 32'h0);
    set_addr(12'h020);
    check("R6 reserved lock still works", rd_v3, 32'h0000_A05F);
    check("R6 reserved never requested", {31'b0, req_v3}, 32'h0);
  endtask

  task automatic t_unmapped();
    bus_write(12'h024, 32'hFFFF_FFFF);
    check("R9 stray write no request", {29'b0, req_v0, req_v1, req_v3}, 32'h0);
    set_addr(12'h024);
    check("R9 unmapped reads zero", rd_v0, 32'h0);
    set_addr(12'h020);
    check("R9 lock untouched", rd_v0, 32'h0000_A05F);
    set_addr(12'h040);
    check("R9 level untouched", rd_v0, 32'h0000_0008);
  endtask

  task automatic t_relock();
    bus_write(12'h020, 32'h0000_1234);
    bus_write(12'h040, 32'h0000_0104);
    check("R3 relocked no request", {30'b0, req_v0, req_v1}, 32'h0);
    set_addr(12'h040);
    check("R3 relocked level kept", rd_v0, 32'h0000_0008);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_mask();
    t_locked_ignore();
    t_unlock_fire();
    t_variant_bits();
    t_reserved();
    t_unmapped();
    t_relock();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule